// File: doc/BRIEF.md
# Dual-Edge Pulse Timestamper

This block timestamps both edges of a pulse on one digital input. It uses a free-running timebase counter for the timestamps and presents the two times as a pair of readable registers. Each detected edge writes the counter value into a hidden staging buffer, not straight into a visible register. A falling edge moves the staged rising time into the first visible register. The staged falling time moves into the second visible register only when software reads the first one.

Because of this, the two registers always describe the same pulse, provided software reads the first register before the second. A flag reports that a new pair is waiting, and reading the second register clears it. The channel input is synchronized inside the block. When capture is disabled, the timebase stops and edges are ignored.

Top module: `dual_edge_stamp`

## Requirements
- R1: While reset is asserted, `lead_time`, `trail_time` and `pair_ready` are 0, and so are the timebase and both hidden buffers.
- R2: The block first sees a level change on `chan_in` at clock edge k. The edge is acted on at clock edge k+2. A rising edge stores the timebase value at that edge (before its increment) into the hidden leading buffer.
- R3: A falling edge copies the hidden leading buffer into `lead_time` at clock edge k+2. After that edge, `lead_time` holds the rise time of the pulse that just ended.
- R4: At the same clock edge, a falling edge stores the timebase value into the hidden trailing buffer.
- R5: A one-cycle `rd_lead` pulse copies the hidden trailing buffer into `trail_time` at the end of that cycle. If a falling edge is acted on in the same cycle, the read still returns the old `lead_time`, and `trail_time` takes the trailing buffer's old contents.
- R6: The timebase is CNT_W (default 16) bits wide. It increments by one on every clock edge at which `cap_en` is 1, wraps from all ones to 0, and holds while `cap_en` is 0.
- R7: When `cap_en` is 0 at the clock edge where an edge would be acted on, the edge is ignored: neither hidden buffer, `lead_time` nor `pair_ready` changes.
- R8: `pair_ready` goes to 1 on the clock edge where `lead_time` is updated by a falling edge. It clears on a clock edge where `rd_trail` is 1. If both happen at the same edge, it is set.
- R9: Without an `rd_lead` pulse, `trail_time` never changes, whatever edges arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Runs the timebase and qualifies edges |
| chan_in | input | 1 | Filtered channel input, asynchronous |
| rd_lead | input | 1 | One-cycle read strobe for `lead_time` |
| rd_trail | input | 1 | One-cycle read strobe for `trail_time` |
| lead_time | output | CNT_W | Visible rising-edge timestamp |
| trail_time | output | CNT_W | Visible falling-edge timestamp |
| pair_ready | output | 1 | A new pair is waiting |

## Verification
Hidden buffers are only visible through later promotions, so a wrong staged value shows up one pulse late. A bad leading buffer appears in `lead_time` at the next falling edge, two clocks after the input falls. A bad trailing buffer appears in `trail_time` only after the next `rd_lead`. A timebase error shifts every later timestamp by the same amount. This means a single miscount is seen at the first completed pulse after it and persists from then on, and the long enabled run is the case that exposes a wrong wrap. A promotion made at the wrong moment, such as `trail_time` moving on a falling edge, is caught on the very next clock by comparison against the bench model.

// File: rtl/des_pkg.sv
package des_pkg;
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_ev_t;
endpackage

// File: rtl/des_timebase.sv
module des_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (run) count <= count + ONE;
   end
endmodule

// File: rtl/des_edge_detect.sv
module des_edge_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic              qual,
   output des_pkg::edge_ev_t ev
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [LAST:0] sync_q;
   logic          prev_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("des_edge_detect: SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];

   always_comb begin
      ev.rise = qual &  sync_q[LAST] & ~prev_q;
      ev.fall = qual & ~sync_q[LAST] &  prev_q;
   end
endmodule

// File: rtl/des_capture_pair.sv
module des_capture_pair #(
   parameter int CNT_W    = 16,
   parameter bit HAS_FLAG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  des_pkg::edge_ev_t ev,
   input  logic [CNT_W-1:0]  stamp,
   input  logic              rd_lead,
   input  logic              rd_trail,
   output logic [CNT_W-1:0]  lead_reg,
   output logic [CNT_W-1:0]  trail_reg,
   output logic [CNT_W-1:0]  lead_buf,
   output logic [CNT_W-1:0]  trail_buf,
   output logic              ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_buf  <= '0;
         trail_buf <= '0;
         lead_reg  <= '0;
         trail_reg <= '0;
      end else begin
         if (ev.rise) lead_buf <= stamp;
         if (ev.fall) begin
            lead_reg  <= lead_buf;
            trail_buf <= stamp;
         end
         if (rd_lead) trail_reg <= trail_buf;
      end
   end

   generate
      if (HAS_FLAG) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ready <= 1'b0;
            else if (ev.fall)  ready <= 1'b1;
            else if (rd_trail) ready <= 1'b0;
         end
      end else begin : g_noflag
         assign ready = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dual_edge_stamp.sv
module dual_edge_stamp #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FLAG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic             chan_in,
   input  logic             rd_lead,
   input  logic             rd_trail,
   output logic [CNT_W-1:0] lead_time,
   output logic [CNT_W-1:0] trail_time,
   output logic             pair_ready
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_w
         $error("dual_edge_stamp: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0]  tb_count;
   logic [CNT_W-1:0]  lead_buf;
   logic [CNT_W-1:0]  trail_buf;
   des_pkg::edge_ev_t ev;

   des_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(cap_en), .count(tb_count));

   des_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(chan_in), .qual(cap_en), .ev(ev));

   des_capture_pair #(.CNT_W(CNT_W), .HAS_FLAG(HAS_FLAG)) u_cap (
      .clk(clk), .rst_n(rst_n), .ev(ev), .stamp(tb_count),
      .rd_lead(rd_lead), .rd_trail(rd_trail),
      .lead_reg(lead_time), .trail_reg(trail_time),
      .lead_buf(lead_buf), .trail_buf(trail_buf), .ready(pair_ready));
endmodule

// File: rtl/des_checker.sv
module des_checker #(
   parameter int CNT_W    = 16,
   parameter bit HAS_FLAG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cap_en,
   input logic             rd_lead,
   input logic             rd_trail,
   input logic             fall,
   input logic             rise,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] lead_buf,
   input logic [CNT_W-1:0] trail_buf,
   input logic [CNT_W-1:0] lead_time,
   input logic [CNT_W-1:0] trail_time,
   input logic             pair_ready
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (lead_time == '0 && trail_time == '0 && !pair_ready));
   a_r2_rise_stamp: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> lead_buf == $past(count));
   a_r3_fall_promote: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> lead_time == $past(lead_buf));
   a_r4_fall_stamp: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> trail_buf == $past(count));
   a_r5_read_promote: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lead |=> trail_time == $past(trail_buf));
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> count == $past(count) + ONE);
   a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(count));
   a_r7_disabled_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> ($stable(lead_time) && $stable(lead_buf) && $stable(trail_buf)));
   a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_FLAG && rd_trail && !fall) |=> !pair_ready);
   a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_FLAG && fall) |=> pair_ready);
   a_r9_trail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lead |=> $stable(trail_time));
endmodule

bind dual_edge_stamp des_checker #(.CNT_W(CNT_W), .HAS_FLAG(HAS_FLAG)) u_chk (
   .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .rd_lead(rd_lead),
   .rd_trail(rd_trail), .fall(ev.fall), .rise(ev.rise), .count(tb_count),
   .lead_buf(lead_buf), .trail_buf(trail_buf), .lead_time(lead_time),
   .trail_time(trail_time), .pair_ready(pair_ready));

// File: tb/tb_dual_edge_stamp.sv
module tb_dual_edge_stamp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_en = 1'b0;
   logic        chan_in = 1'b0;
   logic        rd_lead = 1'b0;
   logic        rd_trail = 1'b0;
   logic [15:0] lead_time, trail_time;
   logic        pair_ready;

   int n_cmp = 0;
   int n_bad = 0;
   int wd = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   dual_edge_stamp dut (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .chan_in(chan_in),
      .rd_lead(rd_lead), .rd_trail(rd_trail), .lead_time(lead_time),
      .trail_time(trail_time), .pair_ready(pair_ready));

   // Bench model built from the requirements (two sync stages, act at k+2)
   logic        m_s1, m_s2, m_prev, m_rdy;
   logic [15:0] m_cnt, m_b1, m_b2, m_r1, m_r2;

   function automatic logic [15:0] next_cnt(logic [15:0] c, logic en);
      return en ? c + 16'd1 : c;
   endfunction

   function automatic logic next_rdy(logic r, logic f, logic rd2);
      if (f) return 1'b1;
      if (rd2) return 1'b0;
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_rdy <= 0;
         m_cnt <= 0; m_b1 <= 0; m_b2 <= 0; m_r1 <= 0; m_r2 <= 0;
      end else begin
         m_s1   <= chan_in;
         m_s2   <= m_s1;
         m_prev <= m_s2;
         m_cnt  <= next_cnt(m_cnt, cap_en);
         if (cap_en && m_s2 && !m_prev) m_b1 <= m_cnt;
         if (cap_en && !m_s2 && m_prev) begin
            m_r1 <= m_b1;
            m_b2 <= m_cnt;
         end
         if (rd_lead) m_r2 <= m_b2;
         m_rdy <= next_rdy(m_rdy, cap_en && !m_s2 && m_prev, rd_trail);
      end
   end

   task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      cmp("R3 lead_time", lead_time, m_r1);
      cmp("R5 trail_time", trail_time, m_r2);
      cmp("R8 pair_ready", {15'd0, pair_ready}, {15'd0, m_rdy});
   endtask

   task automatic step(logic en, logic ch, logic r1, logic r2);
      @(negedge clk);
      check_all();
      cap_en = en; chan_in = ch; rd_lead = r1; rd_trail = r2;
   endtask

   task automatic pulse(int hi, int lo);
      for (int i = 0; i < hi; i++) step(cap_en, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < lo; i++) step(cap_en, 1'b0, 1'b0, 1'b0);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 190000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0123));
      // R1: reset state
      repeat (3) @(negedge clk);
      tag = "R1";
      check_all();
      cmp("R1 lead_time zero", lead_time, 16'd0);
      rst_n = 1'b1;
      cap_en = 1'b1;

      // R2/R3/R4: directed pulse, then read lead then trail
      tag = "R2";
      pulse(5, 6);
      cmp("R2 rise stamp seen in lead_time", lead_time, m_r1);
      tag = "R4";
      step(1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      cmp("R4 fall stamp seen in trail_time", trail_time, m_r2);

      // R5: rd_lead coincides with the falling edge being acted on
      tag = "R5";
      pulse(4, 0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b1, 1'b0);
      pulse(0, 4);

      // R9: several pulses with no reads
      tag = "R9";
      for (int p = 0; p < 5; p++) pulse(3 + p, 4);

      // R7: edges while disabled
      tag = "R7";
      step(1'b0, 1'b0, 1'b0, 1'b0);
      for (int p = 0; p < 4; p++) pulse(3, 3);
      step(1'b1, 1'b0, 1'b0, 1'b0);

      // R8: set and clear at the same edge
      tag = "R8";
      pulse(4, 0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b1);
      pulse(0, 4);

      // Random mix
      tag = "RND";
      for (int i = 0; i < 6000; i++)
         step(($urandom % 8) != 0, ($urandom % 5) == 0 ? ~chan_in : chan_in,
              ($urandom % 9) == 0, ($urandom % 11) == 0);

      // R6: long enabled run across the wrap
      tag = "R6";
      step(1'b1, 1'b0, 1'b0, 1'b0);
      repeat (66000) @(negedge clk);
      pulse(3, 4);
      step(1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      pulse(0, 3);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule